// File: doc/BRIEF.md
# Vector Loop Predicate Generator

This block turns a scalar loop test into a per-lane activity mask for a vector unit. It receives a start index and a limit and treats the number of loop iterations still to run as the number of active lanes. That count is capped to what one vector can hold. The result is written as a byte-granular predicate that has one bit per vector byte, with only the lowest bit of each element marked. The block also derives four condition flags from the predicate.

The caller pulses a strobe together with the two operands and the mode selects. The operands can be taken as 64-bit values, or as 32-bit values widened first. The compare can be signed or unsigned, and strict or inclusive. Elements can be bytes, halfwords, words or doublewords. One clock later the predicate and flags appear on registered outputs with a one-cycle valid pulse. They then hold until the next strobe. The vector length is a parameter that is a multiple of 128 bits, from 128 to 2048.

Top module: `loop_pred_gen`

## Requirements
- R1: With `wide_i`=0, only the low 32 bits of each operand are used. They are zero-extended when `unsigned_i`=1 and sign-extended otherwise, and the upper 32 input bits have no effect on the result.
- R2: The lane count is (limit − start) modulo 2^64, capped unsigned at PRED_W (the vector length in bytes). In inclusive mode (`incl_i`=1) one more lane is added after the cap.
- R3: When start is not below the limit (strict mode), or start is above the limit (inclusive mode), the predicate is all zero. The compare is signed when `unsigned_i`=0 and unsigned when it is 1.
- R4: `esize_i` encodes the element width: 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, 3 for 8 bytes. Predicate bit i is set only if i is a multiple of the element width in bytes and i < count × element width.
- R5: The scaled bit count is bounded to PRED_W. A count larger than the vector sets every element-aligned bit and nothing more.
- R6: `flag_n_o` is 1 exactly when the first element is active (predicate bit 0).
- R7: `flag_z_o` is 1 exactly when no predicate bit is set.
- R8: `flag_c_o` is 1 exactly when the last element is inactive, i.e. bit PRED_W − element width is clear. `flag_v_o` is always 0.
- R9: Results and a single-cycle `valid_o` appear on the clock edge after the one on which `start_i` is sampled high. Without a strobe the predicate and flags keep their values.
- R10: After a synchronous reset, `valid_o`, the predicate and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe: compute from the operands this cycle |
| op_start_i | input | 64 | Start index operand |
| op_limit_i | input | 64 | Limit operand |
| wide_i | input | 1 | 1: 64-bit operands, 0: 32-bit operands widened |
| unsigned_i | input | 1 | 1: unsigned extension and compare |
| incl_i | input | 1 | 1: inclusive (less-or-equal) form |
| esize_i | input | 2 | Element size code (0 byte, 1 half, 2 word, 3 double) |
| valid_o | output | 1 | One-cycle pulse when new results are present |
| pred_o | output | VL_BITS/8 | Predicate, one bit per vector byte |
| flag_n_o | output | 1 | First element active |
| flag_z_o | output | 1 | No element active |
| flag_c_o | output | 1 | Last element inactive |
| flag_v_o | output | 1 | Always zero |

## Verification
Every result, which is the predicate, the four flags and the valid pulse, belongs to the clock edge right after the edge that samples the strobe. The bench raises the strobe on a falling edge and lowers it on the next falling edge. It reads all outputs at that second falling edge, which is half a cycle after they were registered. One cycle later it reads them again to confirm that valid has dropped and that the predicate and flags have held without a strobe.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  typedef enum logic [1:0] {
    ESZ_B = 2'd0,
    ESZ_H = 2'd1,
    ESZ_W = 2'd2,
    ESZ_D = 2'd3
  } esz_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/lpg_count.sv
module lpg_count #(
  parameter int PRED_W = 32,
  localparam int CW = $clog2(PRED_W + 2)
) (
  input  logic [63:0]   op_start,
  input  logic [63:0]   op_limit,
  input  logic          wide,
  input  logic          uns,
  input  logic          incl,
  output logic [CW-1:0] lanes
);
  logic [63:0]   a_ext, b_ext, diff;
  logic [CW-1:0] capped;
  logic          pass;

  always_comb begin
    if (wide) begin
      a_ext = op_start;
      b_ext = op_limit;
    end else if (uns) begin
      a_ext = {32'd0, op_start[31:0]};
      b_ext = {32'd0, op_limit[31:0]};
    end else begin
      a_ext = {{32{op_start[31]}}, op_start[31:0]};
      b_ext = {{32{op_limit[31]}}, op_limit[31:0]};
    end
  end

  assign diff   = b_ext - a_ext;
  assign capped = (diff > 64'(PRED_W)) ? CW'(PRED_W) : diff[CW-1:0];

  always_comb begin
    if (uns) pass = incl ? (a_ext <= b_ext) : (a_ext < b_ext);
    else     pass = incl ? ($signed(a_ext) <= $signed(b_ext))
                         : ($signed(a_ext) <  $signed(b_ext));
  end

  assign lanes = pass ? (capped + CW'(incl)) : '0;
endmodule

// File: rtl/lpg_mask.sv
module lpg_mask
  import lpg_pkg::*;
#(
  parameter int PRED_W = 32,
  localparam int CW = $clog2(PRED_W + 2),
  localparam int BW = CW + 3
) (
  input  logic [CW-1:0]     lanes,
  input  esz_e              esz,
  output logic [PRED_W-1:0] pred
);
  logic [BW-1:0] bit_cnt;

  assign bit_cnt = {3'b000, lanes} << esz;

  for (genvar i = 0; i < PRED_W; i++) begin : g_bit
    localparam bit AL_H = (i % 2) == 0;
    localparam bit AL_W = (i % 4) == 0;
    localparam bit AL_D = (i % 8) == 0;
    logic aligned;
    always_comb begin
      case (esz)
        ESZ_B:   aligned = 1'b1;
        ESZ_H:   aligned = AL_H;
        ESZ_W:   aligned = AL_W;
        default: aligned = AL_D;
      endcase
    end
    assign pred[i] = aligned && (BW'(i) < bit_cnt);
  end
endmodule

// File: rtl/lpg_flags.sv
module lpg_flags
  import lpg_pkg::*;
#(
  parameter int PRED_W = 32
) (
  input  logic [PRED_W-1:0] pred,
  input  esz_e              esz,
  output flags_t            flags
);
  logic last_on;

  always_comb begin
    case (esz)
      ESZ_B:   last_on = pred[PRED_W-1];
      ESZ_H:   last_on = pred[PRED_W-2];
      ESZ_W:   last_on = pred[PRED_W-4];
      default: last_on = pred[PRED_W-8];
    endcase
  end

  assign flags.n = pred[0];
  assign flags.z = ~|pred;
  assign flags.c = ~last_on;
  assign flags.v = 1'b0;
endmodule

// File: rtl/loop_pred_gen.sv
module loop_pred_gen
  import lpg_pkg::*;
#(
  parameter int VL_BITS = 256,
  localparam int PRED_W = VL_BITS / 8,
  localparam int CW = $clog2(PRED_W + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [63:0]       op_start_i,
  input  logic [63:0]       op_limit_i,
  input  logic              wide_i,
  input  logic              unsigned_i,
  input  logic              incl_i,
  input  logic [1:0]        esize_i,
  output logic              valid_o,
  output logic [PRED_W-1:0] pred_o,
  output logic              flag_n_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_v_o
);
  esz_e              esz;
  logic [CW-1:0]     lanes;
  logic [PRED_W-1:0] pred_d;
  flags_t            flags_d;

  assign esz = esz_e'(esize_i);

  lpg_count #(.PRED_W(PRED_W)) u_count (
    .op_start (op_start_i),
    .op_limit (op_limit_i),
    .wide     (wide_i),
    .uns      (unsigned_i),
    .incl     (incl_i),
    .lanes    (lanes)
  );

  lpg_mask #(.PRED_W(PRED_W)) u_mask (
    .lanes (lanes),
    .esz   (esz),
    .pred  (pred_d)
  );

  lpg_flags #(.PRED_W(PRED_W)) u_flags (
    .pred  (pred_d),
    .esz   (esz),
    .flags (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o  <= 1'b0;
      pred_o   <= '0;
      flag_n_o <= 1'b0;
      flag_z_o <= 1'b0;
      flag_c_o <= 1'b0;
      flag_v_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        pred_o   <= pred_d;
        flag_n_o <= flags_d.n;
        flag_z_o <= flags_d.z;
        flag_c_o <= flags_d.c;
        flag_v_o <= flags_d.v;
      end
    end
  end
endmodule

// File: rtl/lpg_chk.sv
module lpg_chk #(
  parameter int PRED_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [63:0]       op_start_i,
  input logic [63:0]       op_limit_i,
  input logic              wide_i,
  input logic              unsigned_i,
  input logic [1:0]        esize_i,
  input logic              valid_o,
  input logic [PRED_W-1:0] pred_o,
  input logic              flag_n_o,
  input logic              flag_z_o,
  input logic              flag_v_o
);
  function automatic logic [PRED_W-1:0] off_dbl();
    logic [PRED_W-1:0] m;
    for (int i = 0; i < PRED_W; i++) m[i] = (i % 8) != 0;
    return m;
  endfunction

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    start_i |=> valid_o); // R9
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> !valid_o); // R9
  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(pred_o)); // R9
  AST_FAIL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (start_i && wide_i && unsigned_i && (op_start_i > op_limit_i)) |=> (pred_o == '0)); // R3
  AST_DBL_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (start_i && esize_i == 2'd3) |=> ((pred_o & off_dbl()) == '0)); // R4
  AST_N_FIRST: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (flag_n_o == pred_o[0])); // R6
  AST_Z_EMPTY: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (flag_z_o == (pred_o == '0))); // R7
  AST_V_CLEAR: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> !flag_v_o); // R8
endmodule

bind loop_pred_gen lpg_chk #(.PRED_W(PRED_W)) u_lpg_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .op_start_i (op_start_i),
  .op_limit_i (op_limit_i),
  .wide_i     (wide_i),
  .unsigned_i (unsigned_i),
  .esize_i    (esize_i),
  .valid_o    (valid_o),
  .pred_o     (pred_o),
  .flag_n_o   (flag_n_o),
  .flag_z_o   (flag_z_o),
  .flag_v_o   (flag_v_o)
);

// File: tb/tb_loop_pred_gen.sv
module tb_loop_pred_gen;
  localparam int PW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [63:0]   op_start_i = '0, op_limit_i = '0;
  logic          wide_i = 1'b1, unsigned_i = 1'b1, incl_i = 1'b0;
  logic [1:0]    esize_i = 2'd0;
  logic          valid_o, flag_n_o, flag_z_o, flag_c_o, flag_v_o;
  logic [PW-1:0] pred_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  loop_pred_gen #(.VL_BITS(PW * 8)) dut (
    .clk(clk), .rst(rst), .start_i(start_i),
    .op_start_i(op_start_i), .op_limit_i(op_limit_i),
    .wide_i(wide_i), .unsigned_i(unsigned_i), .incl_i(incl_i),
    .esize_i(esize_i), .valid_o(valid_o), .pred_o(pred_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
    .flag_v_o(flag_v_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] model(input logic [63:0] s, input logic [63:0] l,
      input logic w, input logic u, input logic inc, input logic [1:0] e);
    logic [63:0] a, b, d;
    longint unsigned cnt, bits;
    logic ok;
    logic [PW-1:0] p;
    a = w ? s : (u ? {32'd0, s[31:0]} : {{32{s[31]}}, s[31:0]});
    b = w ? l : (u ? {32'd0, l[31:0]} : {{32{l[31]}}, l[31:0]});
    if (u) ok = inc ? (a <= b) : (a < b);
    else   ok = inc ? ($signed(a) <= $signed(b)) : ($signed(a) < $signed(b));
    d = b - a;
    cnt = (d > 64'(PW)) ? PW : d;
    if (inc) cnt++;
    if (!ok) cnt = 0;
    bits = cnt << e;
    p = '0;
    for (int i = 0; i < PW; i++)
      if (longint'(i) < bits && (i % (1 << e)) == 0) p[i] = 1'b1;
    return p;
  endfunction

  task automatic run(input string req, input logic [63:0] s, input logic [63:0] l,
      input logic w, input logic u, input logic inc, input logic [1:0] e);
    logic [PW-1:0] ep, held;
    ep = model(s, l, w, u, inc, e);
    @(negedge clk);
    op_start_i = s; op_limit_i = l; wide_i = w; unsigned_i = u;
    incl_i = inc; esize_i = e; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    op_start_i = ~s; op_limit_i = 64'd0; esize_i = ~e;
    chk({req, " R9 valid"}, 64'(valid_o), 64'd1);
    chk({req, " pred"}, 64'(pred_o), 64'(ep));
    chk({req, " R6 n"}, 64'(flag_n_o), 64'(ep[0]));
    chk({req, " R7 z"}, 64'(flag_z_o), 64'(ep == '0));
    chk({req, " R8 c"}, 64'(flag_c_o), 64'(!ep[PW - (1 << e)]));
    chk({req, " R8 v"}, 64'(flag_v_o), 64'd0);
    held = pred_o;
    @(negedge clk);
    chk({req, " R9 pulse"}, 64'(valid_o), 64'd0);
    chk({req, " R9 hold"}, 64'(pred_o), 64'(held));
  endtask

  task automatic t_reset();
    chk("R10 valid", 64'(valid_o), 64'd0);
    chk("R10 pred", 64'(pred_o), 64'd0);
    chk("R10 flags", 64'({flag_n_o, flag_z_o, flag_c_o, flag_v_o}), 64'd0);
  endtask

  task automatic t_basic();
    run("R2 strict", 64'd0, 64'd5, 1, 1, 0, 2'd0);
    chk("R2 strict lanes", 64'(pred_o), 64'h1F);
    run("R2 inclusive", 64'd0, 64'd5, 1, 1, 1, 2'd0);
    chk("R2 inclusive lanes", 64'(pred_o), 64'h3F);
    run("R2 offset", 64'd100, 64'd103, 1, 0, 0, 2'd0);
    chk("R2 offset lanes", 64'(pred_o), 64'h7);
  endtask

  task automatic t_fail();
    run("R3 above", 64'd10, 64'd3, 1, 1, 0, 2'd0);
    chk("R3 above zero", 64'(pred_o), 64'd0);
    run("R3 equal strict", 64'd7, 64'd7, 1, 1, 0, 2'd0);
    chk("R3 equal strict zero", 64'(pred_o), 64'd0);
    run("R3 equal incl", 64'd7, 64'd7, 1, 1, 1, 2'd0);
    chk("R3 equal incl one", 64'(pred_o), 64'd1);
    run("R3 signed neg start", 64'hFFFF_FFFF_FFFF_FFFB, 64'd2, 1, 0, 0, 2'd0);
    chk("R3 signed neg start", 64'(pred_o), 64'h7F);
    run("R3 unsigned big start", 64'hFFFF_FFFF_FFFF_FFFB, 64'd2, 1, 1, 0, 2'd0);
    chk("R3 unsigned big start zero", 64'(pred_o), 64'd0);
  endtask

  task automatic t_narrow();
    run("R1 signed32", 64'hDEAD_0000_FFFF_FFFF, 64'h1234_5678_0000_0002, 0, 0, 0, 2'd0);
    chk("R1 signed32 lanes", 64'(pred_o), 64'h7);
    run("R1 unsigned32", 64'hDEAD_0000_FFFF_FFFF, 64'h1234_5678_0000_0002, 0, 1, 0, 2'd0);
    chk("R1 unsigned32 zero", 64'(pred_o), 64'd0);
    run("R1 upper ignored", 64'hFFFF_0000_0000_0001, 64'h0000_0001_0000_0004, 0, 1, 0, 2'd0);
    chk("R1 upper ignored lanes", 64'(pred_o), 64'h7);
  endtask

  task automatic t_clamp();
    run("R5 full signed", 64'hFFFF_FFFF_FFFF_FFFB, 64'd100, 1, 0, 0, 2'd0);
    chk("R5 full", 64'(pred_o), 64'hFFFF_FFFF);
    run("R5 max incl", 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 1, 2'd0);
    chk("R5 max incl", 64'(pred_o), 64'hFFFF_FFFF);
    run("R5 exact", 64'd0, 64'd32, 1, 1, 0, 2'd0);
    chk("R5 exact", 64'(pred_o), 64'hFFFF_FFFF);
  endtask

  task automatic t_esize();
    run("R4 word", 64'd0, 64'd3, 1, 1, 0, 2'd2);
    chk("R4 word mask", 64'(pred_o), 64'h111);
    run("R4 half full", 64'd0, 64'd16, 1, 1, 0, 2'd1);
    chk("R4 half full", 64'(pred_o), 64'h5555_5555);
    run("R4 dbl clamp", 64'd0, 64'd100, 1, 1, 0, 2'd3);
    chk("R4 dbl clamp", 64'(pred_o), 64'h0101_0101);
    run("R4 dbl partial", 64'd0, 64'd2, 1, 1, 1, 2'd3);
    chk("R4 dbl partial", 64'(pred_o), 64'h01_0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_fail();
    t_narrow();
    t_clamp();
    t_esize();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=%h exp=%h", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule